// File: doc/BRIEF.md
# Single-Bus Processor Datapath with Hardwired Sequencer

This block is a small processor core in which every transfer between the program counter, the instruction register, the general registers, the memory data registers and the adder passes over one shared internal bus. The bus carries one value per clock. An operation therefore moves its first operand into a staging register (Y), combines it with a second value taken from the bus, and parks the result in a result register (Z). A third step puts that result back onto the bus.

A hardwired step counter decodes the current instruction and raises the control strobes for each step. It starts over at the first fetch step after the last step of every instruction. Memory is reached through a plain request/acknowledge port. The sequencer holds its step while a request is outstanding, so memory may take any number of cycles. The same adder does the program-counter increment by selecting a constant 4 in place of Y.

Top module: `sbus_core`

## Requirements
- R1: While reset is low at a clock edge, `pc_o` becomes `RESET_PC`, `zflag_o`, `mem_req`, `rf_we_o` and `instr_done_o` are 0, and the first fetch begins in the first cycle after reset is released.
- R2: Each instruction is fetched from the address in PC. `pc_o` equals that address plus 4 by the last step of the instruction. The fetch takes 3 + W cycles, where W is the number of cycles the request waits for its acknowledge. A new fetch starts in the cycle after `instr_done_o`.
- R3: Instruction word layout: bits 31:24 opcode, 23:20 register field A, 19:16 register field B, 15:0 signed offset. Opcodes: 8'h01 ADD, 8'h02 ADDM, 8'h03 BR, 8'h04 BZ. Every other opcode is a no-operation.
- R4: ADD writes R[A] + R[B] (modulo 2^32) into R[A]. The instruction takes 6 + W cycles.
- R5: ADDM issues a second memory request at address R[B] and writes R[A] plus the returned word into R[A]. The instruction takes 8 + W1 + W2 cycles.
- R6: `zflag_o` is set when the result of an ADD or ADDM is zero and cleared otherwise. The PC increment and the branch-target addition leave it unchanged.
- R7: BR loads PC with the incremented PC plus the sign-extended offset. The instruction takes 6 + W cycles.
- R8: BZ acts as BR when `zflag_o` is 1 (6 + W cycles). Otherwise it ends after decode with PC left at the incremented value (4 + W cycles).
- R9: A no-operation opcode writes no register and does not change the flag. It ends after decode (4 + W cycles).
- R10: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_ack` is seen high at a clock edge.
- R11: In every step at most one source drives the internal bus.
- R12: `rf_we_o` is high only in the last step of ADD or ADDM, and it then carries the destination field A and the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | DW | Byte address of the request |
| mem_rdata | input | DW | Read data, valid together with `mem_ack` |
| mem_ack | input | 1 | Memory function completed |
| pc_o | output | DW | Current program counter |
| zflag_o | output | 1 | Zero flag from the last ADD/ADDM |
| instr_done_o | output | 1 | High during the last step of an instruction |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | RAW | Register being written |
| rf_wdata_o | output | DW | Value being written |

## Verification
The bench builds the core with its defaults: a 32-bit datapath, sixteen registers and a reset PC of 0. With this width, a sum of two large positive words wraps past the sign bit, and a 16-bit offset of all ones gives a backward branch. The memory model in the bench stretches each acknowledge by 0, 1 or 2 cycles in rotation. This puts fetches and operand reads of ADDM through every stall length, and each instruction's cycle count is compared against the formula in its requirement. The program covers a taken branch, an untaken branch, an undefined opcode and a zero result.

// File: rtl/sbus_pkg.sv
// Shared encoding constants and the control-strobe bundle of the single-bus core.
// Assumes a 32-bit instruction word held in the low bits of the datapath.
package sbus_pkg;
    localparam int OP_LO  = 24;
    localparam int OP_W   = 8;
    localparam int FA_LO  = 20;
    localparam int FB_LO  = 16;
    localparam int OFF_W  = 16;
    localparam int STEP_W = 3;

    localparam logic [OP_W-1:0] OPC_ADD  = 8'h01;
    localparam logic [OP_W-1:0] OPC_ADDM = 8'h02;
    localparam logic [OP_W-1:0] OPC_BR   = 8'h03;
    localparam logic [OP_W-1:0] OPC_BZ   = 8'h04;

    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic z_out;
        logic z_in;
        logic y_in;
        logic mdr_out;
        logic mar_in;
        logic ir_in;
        logic rf_out;
        logic rf_in;
        logic rf_sel_b;
        logic off_out;
        logic sel_four;
        logic flag_upd;
        logic mem_req;
        logic done;
    } ctl_t;
endpackage

// File: rtl/sbus_regfile.sv
// General register file: one read port, one write port, all words cleared by reset.
// Assumes the write and the read never need the same word in the same step.
module sbus_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_word
        logic [DW-1:0] q;
        // Hold one register, loading it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && waddr == AW'(g))
                q <= wdata;
        end
        assign words[g] = q;
    end

    assign rdata = words[raddr];
endmodule

// File: rtl/sbus_alu.sv
// Combinational adder: one operand is Y or the constant 4, the other is the bus.
// Assumes no storage; the caller latches the sum into Z.
module sbus_alu #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] y_val,
    input  logic [DW-1:0] bus_val,
    input  logic          sel_four,
    output logic [DW-1:0] sum,
    output logic          zero
);
    localparam logic [DW-1:0] INC = DW'(4);

    // Pick the left operand and add.
    always_comb begin
        sum  = (sel_four ? INC : y_val) + bus_val;
        zero = (sum == '0);
    end
endmodule

// File: rtl/sbus_ctrl.sv
// Hardwired step counter and decoder: one control step per clock, stalls while a
// memory request waits for acknowledge, returns to step 0 after the last step.
// Assumes the opcode input is stable from step 3 onward (IR loads at end of step 2).
module sbus_ctrl
    import sbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            zflag,
    input  logic            mem_ack,
    output ctl_t            ctl
);
    logic [STEP_W-1:0] step;

    // Advance, hold on a pending request, or restart after the final step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (ctl.done)
            step <= '0;
        else if (ctl.mem_req && !mem_ack)
            step <= step;
        else
            step <= step + 1'b1;
    end

    // Decode the strobes of the current step.
    always_comb begin
        ctl = '0;
        case (step)
            3'd0: begin ctl.pc_out = 1'b1; ctl.mar_in = 1'b1; ctl.sel_four = 1'b1; ctl.z_in = 1'b1; end
            3'd1: begin ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.mem_req = 1'b1; end
            3'd2: begin ctl.mdr_out = 1'b1; ctl.ir_in = 1'b1; end
            default: begin
                if (opcode == OPC_ADD) begin
                    case (step)
                        3'd3: begin ctl.rf_out = 1'b1; ctl.y_in = 1'b1; end
                        3'd4: begin ctl.rf_out = 1'b1; ctl.rf_sel_b = 1'b1; ctl.z_in = 1'b1; ctl.flag_upd = 1'b1; end
                        default: begin ctl.z_out = 1'b1; ctl.rf_in = 1'b1; ctl.done = 1'b1; end
                    endcase
                end else if (opcode == OPC_ADDM) begin
                    case (step)
                        3'd3: begin ctl.rf_out = 1'b1; ctl.rf_sel_b = 1'b1; ctl.mar_in = 1'b1; end
                        3'd4: ctl.mem_req = 1'b1;
                        3'd5: begin ctl.rf_out = 1'b1; ctl.y_in = 1'b1; end
                        3'd6: begin ctl.mdr_out = 1'b1; ctl.z_in = 1'b1; ctl.flag_upd = 1'b1; end
                        default: begin ctl.z_out = 1'b1; ctl.rf_in = 1'b1; ctl.done = 1'b1; end
                    endcase
                end else if (opcode == OPC_BR || opcode == OPC_BZ) begin
                    case (step)
                        3'd3: begin
                            ctl.pc_out = 1'b1;
                            ctl.y_in   = 1'b1;
                            ctl.done   = (opcode == OPC_BZ) && !zflag;
                        end
                        3'd4: begin ctl.off_out = 1'b1; ctl.z_in = 1'b1; end
                        default: begin ctl.z_out = 1'b1; ctl.pc_in = 1'b1; ctl.done = 1'b1; end
                    endcase
                end else begin
                    ctl.done = 1'b1;
                end
            end
        endcase
    end

    // R2
    step_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.done |=> (step == '0));
endmodule

// File: rtl/sbus_core.sv
// Single-bus core top: PC, IR, MAR, MDR, Y, Z, zero flag, register file, adder and
// sequencer. Every register load happens on the rising clock edge.
// Assumes DW >= 32 so that the instruction word fits in the datapath.
module sbus_core
    import sbus_pkg::*;
#(
    parameter int            DW       = 32,
    parameter int            NREG     = 16,
    parameter logic [DW-1:0] RESET_PC = '0,
    localparam int           RAW      = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic           mem_req,
    output logic [DW-1:0]  mem_addr,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic [DW-1:0]  pc_o,
    output logic           zflag_o,
    output logic           instr_done_o,
    output logic           rf_we_o,
    output logic [RAW-1:0] rf_waddr_o,
    output logic [DW-1:0]  rf_wdata_o
);
    logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q, y_q, z_q;
    logic          zflag_q;
    logic [DW-1:0] bus, rf_rdata, alu_sum, off_ext;
    logic          alu_zero;
    ctl_t          ctl;

    sbus_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (ir_q[OP_LO +: OP_W]),
        .zflag   (zflag_q),
        .mem_ack (mem_ack),
        .ctl     (ctl)
    );

    sbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl.rf_in),
        .waddr (ir_q[FA_LO +: RAW]),
        .wdata (bus),
        .raddr (ctl.rf_sel_b ? ir_q[FB_LO +: RAW] : ir_q[FA_LO +: RAW]),
        .rdata (rf_rdata)
    );

    sbus_alu #(.DW(DW)) u_alu (
        .y_val    (y_q),
        .bus_val  (bus),
        .sel_four (ctl.sel_four),
        .sum      (alu_sum),
        .zero     (alu_zero)
    );

    assign off_ext = {{(DW-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

    // Merge the gated sources onto the shared bus.
    always_comb begin
        bus = ({DW{ctl.pc_out}}  & pc_q)
            | ({DW{ctl.z_out}}   & z_q)
            | ({DW{ctl.mdr_out}} & mdr_q)
            | ({DW{ctl.rf_out}}  & rf_rdata)
            | ({DW{ctl.off_out}} & off_ext);
    end

    // Program counter: load from the bus when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)         pc_q <= RESET_PC;
        else if (ctl.pc_in) pc_q <= bus;
    end

    // Instruction, address, staging and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            mar_q <= '0;
            y_q   <= '0;
            z_q   <= '0;
        end else begin
            if (ctl.ir_in)  ir_q  <= bus;
            if (ctl.mar_in) mar_q <= bus;
            if (ctl.y_in)   y_q   <= bus;
            if (ctl.z_in)   z_q   <= alu_sum;
        end
    end

    // Memory data register: captures read data on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mdr_q <= '0;
        else if (ctl.mem_req && mem_ack) mdr_q <= mem_rdata;
    end

    // Zero flag: updated only by instruction-level additions.
    always_ff @(posedge clk) begin
        if (!rst_n)                        zflag_q <= 1'b0;
        else if (ctl.z_in && ctl.flag_upd) zflag_q <= alu_zero;
    end

    assign mem_req      = ctl.mem_req;
    assign mem_addr     = mar_q;
    assign pc_o         = pc_q;
    assign zflag_o      = zflag_q;
    assign instr_done_o = ctl.done;
    assign rf_we_o      = ctl.rf_in;
    assign rf_waddr_o   = ir_q[FA_LO +: RAW];
    assign rf_wdata_o   = bus;

    // R11
    bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.pc_out, ctl.z_out, ctl.mdr_out, ctl.rf_out, ctl.off_out}));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R12
    wr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> instr_done_o);

    // R6
    zflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl.z_in && ctl.flag_upd) |=> $stable(zflag_q));
endmodule

// File: tb/sbus_core_tb.sv
// Bench: behavioural instruction-level model with per-cycle timing prediction,
// a memory responder with rotating wait states, compared on every negative edge.
module sbus_core_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_req, mem_ack;
    logic [31:0] mem_addr, mem_rdata, pc_o, rf_wdata_o;
    logic        zflag_o, instr_done_o, rf_we_o;
    logic [3:0]  rf_waddr_o;

    always #10 clk = ~clk;

    sbus_core u_dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .pc_o(pc_o), .zflag_o(zflag_o),
        .instr_done_o(instr_done_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o)
    );

    int checks = 0, fails = 0;
    logic [31:0] mem [0:63];
    logic [31:0] m_reg [16];
    logic [31:0] m_pc, last_addr;
    logic [31:0] q_addr [$];
    bit          m_z, prev_req, run;
    int          cyc, exp_len, mk, racc, wcnt, ndone;
    string       tag;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wst(int k);
        return k % 3;
    endfunction

    function automatic logic [31:0] enc(logic [7:0] op, logic [3:0] a, logic [3:0] b, logic [15:0] off);
        return {op, a, b, off};
    endfunction

    // Predict the request addresses and cycle count of the instruction at m_pc.
    task automatic start_instr();
        logic [31:0] ins;
        ins = mem[m_pc[7:2]];
        exp_len = 3 + wst(mk); mk++;
        q_addr.push_back(m_pc);
        case (ins[31:24])
            8'h01: begin exp_len += 3; tag = "R4"; end
            8'h02: begin
                q_addr.push_back(m_reg[ins[19:16]]);
                exp_len += 5 + wst(mk); mk++; tag = "R5";
            end
            8'h03: begin exp_len += 3; tag = "R7"; end
            8'h04: begin exp_len += (m_z ? 3 : 1); tag = "R8"; end
            default: begin exp_len += 1; tag = "R9"; end
        endcase
        cyc = 0;
    endtask

    // Per-cycle comparison and memory responder.
    always @(negedge clk) begin
        if (run) begin
            logic [31:0] ins, sum, e;
            cyc++;
            if (mem_req && !prev_req) begin
                if (q_addr.size() == 0) chk(1'b0, "R2 unexpected request", mem_addr, 32'h0);
                else begin
                    e = q_addr.pop_front();
                    chk(mem_addr == e, "R2/R5 request address", mem_addr, e);
                end
            end else if (mem_req && prev_req)
                chk(mem_addr == last_addr, "R10 address held", mem_addr, last_addr);
            if (instr_done_o) begin
                ins = mem[m_pc[7:2]];
                chk(cyc == exp_len, {tag, " cycle count"}, cyc, exp_len);
                chk(pc_o == m_pc + 32'd4, "R2 pc increment", pc_o, m_pc + 32'd4);
                if (ins[31:24] == 8'h01 || ins[31:24] == 8'h02) begin
                    if (ins[31:24] == 8'h01) sum = m_reg[ins[23:20]] + m_reg[ins[19:16]];
                    else sum = m_reg[ins[23:20]] + mem[m_reg[ins[19:16]][7:2]];
                    chk(rf_we_o == 1'b1, "R12 write strobe", rf_we_o, 1);
                    chk(rf_waddr_o == ins[23:20], {tag, " destination"}, rf_waddr_o, ins[23:20]);
                    chk(rf_wdata_o == sum, {tag, " sum"}, rf_wdata_o, sum);
                    m_reg[ins[23:20]] = sum;
                    m_z = (sum == 32'h0);
                end else
                    chk(rf_we_o == 1'b0, {tag, " no write"}, rf_we_o, 0);
                chk(zflag_o == m_z, "R6 zero flag", zflag_o, m_z);
                m_pc = m_pc + 32'd4;
                if (ins[31:24] == 8'h03 || (ins[31:24] == 8'h04 && m_z))
                    m_pc = m_pc + {{16{ins[15]}}, ins[15:0]};
                ndone++;
                start_instr();
            end else
                chk(rf_we_o == 1'b0, "R12 write outside last step", rf_we_o, 0);
            if (mem_req && wcnt == wst(racc)) begin
                mem_ack = 1'b1; mem_rdata = mem[mem_addr[7:2]]; racc++; wcnt = 0;
            end else begin
                mem_ack = 1'b0;
                if (mem_req) wcnt++;
            end
            prev_req  = mem_req;
            last_addr = mem_addr;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        for (int i = 0; i < 16; i++) m_reg[i] = 32'h0;
        mem[0]  = 32'h0000_0040;
        mem[1]  = enc(8'h02, 4'd1, 4'd0, 16'h0);
        mem[2]  = enc(8'h02, 4'd2, 4'd1, 16'h0);
        mem[3]  = enc(8'h02, 4'd3, 4'd1, 16'h0);
        mem[4]  = enc(8'h01, 4'd3, 4'd2, 16'h0);
        mem[5]  = enc(8'h01, 4'd6, 4'd0, 16'h0);
        mem[6]  = enc(8'h04, 4'd0, 4'd0, 16'd8);
        mem[7]  = enc(8'h01, 4'd2, 4'd2, 16'h0);
        mem[8]  = enc(8'h01, 4'd2, 4'd2, 16'h0);
        mem[9]  = enc(8'h01, 4'd3, 4'd2, 16'h0);
        mem[10] = enc(8'h04, 4'd0, 4'd0, 16'd4);
        mem[11] = enc(8'h02, 4'd5, 4'd1, 16'h0);
        mem[12] = 32'hEE12_3456;
        mem[13] = enc(8'h03, 4'd0, 4'd0, 16'hFFFC);
        mem[16] = 32'h7FFF_FFFF;
        run = 0; rst_n = 1'b0; mem_ack = 1'b0; mem_rdata = 32'h0;
        m_pc = 32'h0; m_z = 0; mk = 0; racc = 0; wcnt = 0; ndone = 0;
        prev_req = 0; last_addr = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 32'h0, "R1 reset pc", pc_o, 32'h0);
        chk(zflag_o == 1'b0, "R1 reset flag", zflag_o, 0);
        chk(mem_req == 1'b0, "R1 reset request", mem_req, 0);
        chk(rf_we_o == 1'b0, "R1 reset write", rf_we_o, 0);
        chk(instr_done_o == 1'b0, "R1 reset done", instr_done_o, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        start_instr();
        run = 1;
        for (int i = 0; i < 5000 && ndone < 18; i++) @(posedge clk);
        if (ndone < 18) chk(1'b0, "R2 watchdog expired", ndone, 18);
        run = 0;
        // R3/R7 final state: looping on the backward branch at word 13
        chk(m_pc == 32'd52, "R7 backward branch target", m_pc, 32'd52);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule